// File: doc/BRIEF.md
# Paged GPIO Edge Interrupt Controller

This block provides 48 general-purpose lines arranged as six 8-bit ports behind a byte-wide register bus with a 16-byte address window. Each port has an output latch that drives an open-drain sink output: a latch bit of 1 pulls the line low, and 0 releases it so the line can be used as an input. Reading a port offset returns the levels present on the pins. Writes take effect on the clock edge; reads are combinational from the address.

The lower three ports (lines 0 to 23) can capture edges. Each of these lines has an enable bit, a polarity bit and a sticky pending flag. A small page state machine chooses which of three register pages (enable, polarity, pending) appears at the three shared offsets 8, 9 and 10. The page machine has three states: PG_ID (pending page, the reset state), PG_EN (enable page) and PG_POL (polarity page). A write of 0x80 to offset 7 moves it to PG_EN, 0x40 to PG_POL and 0xC0 to PG_ID, from any state. Any other value written there leaves the state unchanged, and so does every cycle without such a write. To acknowledge an event, software clears the line's enable bit and then sets it again. A summary register at offset 6 and a single active-high interrupt output tell the host which ports hold events.

Top module: `pgpio_ctrl`

## Requirements
- R1: A write to offset p (0 to 5) loads byte p of the output latch, which appears on pin_sink[8p+7:8p] on the following cycle; reset clears all latch bits to 0.
- R2: A read of offset p (0 to 5) returns pin_in[8p+7:8p].
- R3: Offset 7 reads the current page code. Reset gives 0xC0. Writing 0x80, 0x40 or 0xC0 selects the enable, polarity or pending page. Any other value written to offset 7 is ignored.
- R4: The polarity bit of a line selects rising-edge capture when 1 and falling-edge capture when 0. An edge of the opposite direction does not set the flag.
- R5: An edge sets a pending flag only when the line's enable bit is 1. Lines 24 to 47 never raise events. After reset all enables and polarities are 0.
- R6: A pending flag stays set after its pin returns. Writing 0 to its enable bit clears the flag on that write. Setting the bit to 1 again does not restore the flag, and a later matching edge sets it again.
- R7: Offset 6 returns in bit p (p = 0 to 2) the OR of port p's pending flags. Bits 7:3 read 0.
- R8: irq_out is the OR of all pending flags. It stays high until every flag has been cleared.
- R9: In the pending page, offset 8+p reads port p's pending flags, and writes to offsets 8 to 10 are ignored. In the enable and polarity pages these offsets read and write that page's bits.
- R10: Offsets 11 to 15 read as 0.
- R11: Pins pass through a two-stage synchroniser. A pin change made before rising edge 1 is not yet visible on irq_out after edge 2. It is visible after edge 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 48 | Pin levels |
| pin_sink | output | 48 | Open-drain pull-low enables (output latch) |
| irq_out | output | 1 | Interrupt, active high |

## Verification
The bench drives an edge against the wrong polarity and expects no flag. A design that ignored polarity would capture every edge. It writes 0xEE to an enable register that holds two pending flags and expects both flags gone after the flags are re-armed. A design that cleared the flags only on a later edge, or kept them through the toggle, would still show them. It writes zero to the pending page and tries a stray page code. A design that decoded either one would lose flags or switch the page. It also checks R11's window cycle by cycle, where a missing synchroniser stage raises the interrupt one edge early and an extra stage raises it one edge late.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [BYTE_W-1:0] {
        PG_EN  = 8'h80,
        PG_POL = 8'h40,
        PG_ID  = 8'hC0
    } page_e;

    localparam int SUM_OFS  = 6;
    localparam int PAGE_OFS = 7;
    localparam int WIN_OFS  = 8;
endpackage

// File: rtl/pgpio_page_fsm.sv
module pgpio_page_fsm
    import pgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [BYTE_W-1:0] sel_data,
    output page_e             page,
    output logic [BYTE_W-1:0] page_code
);
    page_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_ID;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_EN, PG_POL, PG_ID: begin
                if (sel_wr) begin
                    if (sel_data == PG_EN)       state_d = PG_EN;
                    else if (sel_data == PG_POL) state_d = PG_POL;
                    else if (sel_data == PG_ID)  state_d = PG_ID;
                end
            end
        endcase
    end

    always_comb begin
        page      = state_q;
        page_code = state_q;
    end

    a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(state_q));
    a_r3_page_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_EN) || (state_q == PG_POL) || (state_q == PG_ID));
endmodule

// File: rtl/pgpio_edge_port.sv
module pgpio_edge_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         en_wr,
    input  logic         pol_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] pend_q
);
    logic [W-1:0] s1_q, s2_q, prev_q, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= pins;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // rising when polarity 1, falling when polarity 0
    always_comb begin
        for (int i = 0; i < W; i++)
            hit[i] = en_q[i] && (s2_q[i] != prev_q[i]) && (s2_q[i] == pol_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            pend_q <= '0;
        end else begin
            if (pol_wr) pol_q <= wdata;
            if (en_wr) begin
                en_q   <= wdata;
                pend_q <= pend_q & wdata;
            end else begin
                pend_q <= pend_q | hit;
            end
        end
    end

    a_r5_no_pend_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(en_q)) == '0));
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/pgpio_ctrl.sv
module pgpio_ctrl
    import pgpio_pkg::*;
#(
    parameter int NPORT     = 6,
    parameter int NIRQ_PORT = 3,
    parameter int AW        = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic [BYTE_W-1:0]       bus_wdata,
    output logic [BYTE_W-1:0]       bus_rdata,
    input  logic [NPORT*BYTE_W-1:0] pin_in,
    output logic [NPORT*BYTE_W-1:0] pin_sink,
    output logic                    irq_out
);
    localparam int W = BYTE_W;

    page_e                         page;
    logic [W-1:0]                  page_code;
    logic [NIRQ_PORT-1:0][W-1:0]   en_all, pol_all, pend_all;
    logic [NIRQ_PORT-1:0]          summary;
    logic [NPORT*W-1:0]            latch_q;
    logic                          en_win_wr;

    pgpio_page_fsm i_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (bus_wr && (int'(bus_addr) == PAGE_OFS)),
        .sel_data  (bus_wdata),
        .page      (page),
        .page_code (page_code)
    );

    for (genvar p = 0; p < NIRQ_PORT; p++) begin : g_irq_port
        pgpio_edge_port #(.W(W)) i_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins   (pin_in[p*W +: W]),
            .en_wr  (bus_wr && (int'(bus_addr) == WIN_OFS + p) && (page == PG_EN)),
            .pol_wr (bus_wr && (int'(bus_addr) == WIN_OFS + p) && (page == PG_POL)),
            .wdata  (bus_wdata),
            .en_q   (en_all[p]),
            .pol_q  (pol_all[p]),
            .pend_q (pend_all[p])
        );
        assign summary[p] = |pend_all[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else begin
            for (int p = 0; p < NPORT; p++)
                if (bus_wr && (int'(bus_addr) == p)) latch_q[p*W +: W] <= bus_wdata;
        end
    end

    assign pin_sink = latch_q;
    assign irq_out  = |summary;

    always_comb begin
        int a;
        a = int'(bus_addr);
        bus_rdata = '0;
        if (a < NPORT) begin
            bus_rdata = pin_in[a*W +: W];
        end else if (a == SUM_OFS) begin
            bus_rdata = W'(summary);
        end else if (a == PAGE_OFS) begin
            bus_rdata = page_code;
        end else if (a >= WIN_OFS && a < WIN_OFS + NIRQ_PORT) begin
            unique case (page)
                PG_EN:  bus_rdata = en_all[a-WIN_OFS];
                PG_POL: bus_rdata = pol_all[a-WIN_OFS];
                PG_ID:  bus_rdata = pend_all[a-WIN_OFS];
            endcase
        end
    end

    assign en_win_wr = bus_wr && (page == PG_EN) &&
                       (int'(bus_addr) >= WIN_OFS) && (int'(bus_addr) < WIN_OFS + NIRQ_PORT);

    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !en_win_wr) |=> irq_out);
    a_r1_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == 0) |=> (pin_sink[W-1:0] == $past(bus_wdata)));
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) >= WIN_OFS + NIRQ_PORT) |-> (bus_rdata == '0));
endmodule

// File: tb/test_pgpio_ctrl.sv
module test_pgpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pins = '0;
    logic [47:0] pin_sink;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    logic rd_act = 1'b0;

    typedef struct {
        logic [3:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    pgpio_ctrl i_pgpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
        .pin_sink(pin_sink), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read items and compares
    always @(negedge clk) begin
        #2;
        if (rd_act && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, 64'(bus_rdata), 64'(it.exp));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; rd_act = 1'b1;
        @(negedge clk);
        rd_act = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // reset state
        check("R1 reset latch", 64'(pin_sink), 64'h0);
        check("R8 reset irq", 64'(irq_out), 64'h0);
        rd(4'd7, 8'hC0, "R3 reset page");
        rd(4'd6, 8'h00, "R7 reset summary");
        rd(4'd8, 8'h00, "R9 reset pending");

        // output latches
        wr(4'd0, 8'hA5);
        wr(4'd5, 8'h3C);
        check("R1 latch port0", 64'(pin_sink[7:0]), 64'hA5);
        check("R1 latch port5", 64'(pin_sink[47:40]), 64'h3C);

        // pin reads
        pins[15:8]  = 8'h5A;
        pins[39:32] = 8'hC3;
        rd(4'd1, 8'h5A, "R2 read port1");
        rd(4'd4, 8'hC3, "R2 read port4");
        pins = '0;
        idle(4);

        // page select
        wr(4'd7, 8'h13);
        rd(4'd7, 8'hC0, "R3 stray page code");
        wr(4'd7, 8'h80);
        rd(4'd7, 8'h80, "R3 enable page");
        wr(4'd8, 8'hFF);
        wr(4'd9, 8'h01);
        rd(4'd8, 8'hFF, "R9 enable readback");
        wr(4'd7, 8'h40);
        rd(4'd8, 8'h00, "R5 reset polarity");
        wr(4'd8, 8'h0F);
        rd(4'd8, 8'h0F, "R9 polarity readback");
        wr(4'd7, 8'hC0);

        // line0 rising (pol 1) and line4 rising (pol 0): latency window
        @(negedge clk);
        pins[0] = 1'b1; pins[4] = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        check("R11 not before edge 3", 64'(irq_out), 64'h0);
        @(posedge clk); #2;
        check("R11 visible after edge 3", 64'(irq_out), 64'h1);
        rd(4'd8, 8'h01, "R4 rising only on pol1");
        rd(4'd6, 8'h01, "R7 summary port0");

        // sticky and falling edge on line4
        pins[0] = 1'b0; pins[4] = 1'b0;
        idle(4);
        rd(4'd8, 8'h11, "R6 sticky and R4 falling");

        // port1 line8 falling polarity
        pins[8] = 1'b1; idle(4);
        rd(4'd9, 8'h00, "R4 rise ignored on pol0");
        pins[8] = 1'b0; idle(4);
        rd(4'd9, 8'h01, "R4 fall captured");
        rd(4'd6, 8'h03, "R7 summary two ports");

        // disabled port2 and non-interrupt ports
        pins[16] = 1'b1; pins[40] = 1'b1; idle(4);
        pins[16] = 1'b0; pins[40] = 1'b0; idle(4);
        rd(4'd10, 8'h00, "R5 disabled line no capture");
        rd(4'd6, 8'h03, "R5 upper ports no events");

        // writes to pending page ignored
        wr(4'd8, 8'h00);
        rd(4'd8, 8'h11, "R9 pending write ignored");

        // unmapped offsets
        for (int a = 11; a < 16; a++) rd(4'(a), 8'h00, "R10 unmapped");

        // acknowledge by toggling enable
        wr(4'd7, 8'h80);
        wr(4'd8, 8'hEE);
        wr(4'd8, 8'hFF);
        wr(4'd7, 8'hC0);
        rd(4'd8, 8'h00, "R6 toggle clears");
        check("R8 irq held by port1", 64'(irq_out), 64'h1);
        wr(4'd7, 8'h80);
        wr(4'd9, 8'h00);
        check("R8 irq low after all cleared", 64'(irq_out), 64'h0);
        rd(4'd6, 8'h00, "R7 summary cleared");
        wr(4'd9, 8'h01);
        wr(4'd7, 8'hC0);
        pins[8] = 1'b1; idle(4);
        pins[8] = 1'b0; idle(4);
        rd(4'd9, 8'h01, "R6 re-armed capture");
        check("R8 irq after rearm", 64'(irq_out), 64'h1);

        idle(2);
        summary_and_end();
    end
endmodule